// File: doc/BRIEF.md
# Timer Time-Base with Update Control

This block is the time-base of a general-purpose timer. A prescaler divides the clock by a programmable amount. Each terminal count of the prescaler steps a counter up or down between zero and an auto-reload limit. When the counter wraps, the block raises an update event. Software can also request an update event with a strobe, and so can a slave controller. On an update event the active (shadow) copies of the reload limit and of the prescaler divisor take their preload values. A sticky flag, gated by an enable, drives the interrupt/DMA request.

Five control bits shape this behaviour:

- **Update disable** suppresses update events and keeps the shadows frozen. Reinitialisation strobes still reset the counter and the prescaler.
- **Request-source select** narrows the flag to counter wraps only.
- **One-pulse** stops the counter at its next update event.
- **Trigger-start** turns the counter on in hardware.
- **Counting mode** selects edge-aligned or one of three non-edge codes. Any non-edge code locks the direction bit. A switch from edge-aligned to a non-edge code is refused while the counter runs.

The run control is a two-state machine:

- `RS_IDLE` goes to `RS_RUN` on a configuration write with enable set, or on a trigger-start strobe.
- `RS_RUN` goes to `RS_IDLE` on a configuration write with enable clear, or on an update event while one-pulse is set.
- The stop on an update event wins over any start in the same cycle.

Top module: `tbase_ctl`

## Requirements
- R1: After reset the block is in `RS_IDLE` with `run_o`=0, `cnt_o`=0, `uev_o`=0 and `flag_o`=0. A `cfg_wr` with `cfg_en`=1 moves it to `RS_RUN`, and `cfg_en`=0 moves it back to `RS_IDLE`. A `trig_start` pulse moves it to `RS_RUN`.
- R2: While running, the prescaler counts 0..`psc_act_o` and then steps the counter. With direction 0 the counter counts up and wraps from `arr_act_o` to 0. With direction 1 it counts down and wraps from 0 to the reload value. A wrap therefore happens every (`arr_act_o`+1)*(`psc_act_o`+1) cycles.
- R3: With one-pulse set, an update event returns the block to `RS_IDLE`. The counter then holds its wrapped value.
- R4: With update-disable set, no update event is produced and both shadows hold. `sw_ug` and `slv_rst` still reinitialise the counter and clear the prescaler.
- R5: With update-disable clear, a wrap, `sw_ug` or `slv_rst` produces an update event. `uev_o` is high for exactly the one cycle after the cause, and the shadows take `arr_pre`/`psc_pre` on the same edge.
- R6: With request-source 0, every update event sets `flag_o`. With request-source 1, only a counter wrap sets it. A wrap on the same edge as a reinitialisation strobe counts as a reinitialisation and not as a wrap.
- R7: `flag_o` stays set until a `flag_clr` pulse. If a set and a clear fall on the same edge, the set wins. `irq_o` = `flag_o` AND `upd_ie`.
- R8: While the mode (`cfg_mode`: 0 edge-aligned, 1..3 non-edge) is non-edge, a configuration write leaves the direction unchanged.
- R9: While running in edge-aligned mode, a write asking for a non-edge mode leaves the mode at edge-aligned. The direction in the same write still applies.
- R10: A reinitialisation clears the prescaler. It sets the counter to 0 when counting up. When counting down, it sets the counter to the reload value that will be active after that edge: the preload if an update event occurs, otherwise the old shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Counter enable value |
| cfg_dir | input | 1 | Direction value (0 up, 1 down) |
| cfg_mode | input | 2 | Counting mode (0 edge-aligned) |
| cfg_opm | input | 1 | One-pulse value |
| cfg_urs | input | 1 | Request-source select value |
| cfg_udis | input | 1 | Update-disable value |
| upd_ie | input | 1 | Interrupt/DMA request enable |
| sw_ug | input | 1 | Software update-generate strobe |
| slv_rst | input | 1 | Slave-controller update/reset strobe |
| trig_start | input | 1 | Hardware start strobe |
| flag_clr | input | 1 | Flag clear strobe |
| arr_pre | input | CNT_W | Reload preload value |
| psc_pre | input | PSC_W | Prescaler preload value |
| cnt_o | output | CNT_W | Counter value |
| uev_o | output | 1 | Update event pulse |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Interrupt/DMA request |
| run_o | output | 1 | Counter running |
| dir_o | output | 1 | Current direction |
| arr_act_o | output | CNT_W | Active reload value |
| psc_act_o | output | PSC_W | Active prescaler divisor |

## Verification
A natural wrap and a reinitialisation strobe can fall on the same edge. The bench provokes this by counting cycles from a start: it fires `sw_ug` on exactly the edge where the counter reaches its wrap. It checks the result twice, once with request-source 1 and once with request-source 0. The flag must stay clear under 1 and be set under 0, and the counter must show the reinitialised value. A second collision pairs a flag set with `flag_clr` on the same edge, and the bench expects the set to win. A cycle-accurate model in the bench is compared on every cycle throughout.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE  = 2'd0,
        MODE_CTR_A = 2'd1,
        MODE_CTR_B = 2'd2,
        MODE_QUAD  = 2'd3
    } cmode_t;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } run_st_t;

    typedef struct packed {
        cmode_t mode;
        logic   dir;
        logic   opm;
        logic   urs;
        logic   udis;
    } tb_cfg_t;
endpackage

// File: rtl/tbase_run_fsm.sv
module tbase_run_fsm
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_en,
    input  logic trig_start,
    input  logic opm,
    input  logic upd_now,
    output logic run
);
    run_st_t state_q, state_d;

    // Next-state logic: a one-pulse stop beats any start seen on the same edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: begin
                if (trig_start || (cfg_wr && cfg_en))
                    state_d = RS_RUN;
            end
            RS_RUN: begin
                if (cfg_wr && !cfg_en)
                    state_d = RS_IDLE;
                if (trig_start)
                    state_d = RS_RUN;
            end
            default: state_d = RS_IDLE;
        endcase
        if (opm && upd_now)
            state_d = RS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == RS_RUN);
    end

    assert_opm_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opm && upd_now) |=> !run);
    assert_trig_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_start && !(opm && upd_now)) |=> run);
endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reinit,
    input  logic [PSC_W-1:0] psc_act,
    output logic             tick
);
    logic [PSC_W-1:0] pc_q;

    always_comb begin
        tick = run && (pc_q == psc_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= '0;
        else if (reinit) pc_q <= '0;
        else if (run)    pc_q <= tick ? '0 : pc_q + 1'b1;
    end

    assert_psc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (pc_q == '0));
    assert_psc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reinit && !tick) |=> (pc_q == PSC_W'($past(pc_q) + 1'b1)));
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reinit,
    input  logic             dir,
    input  logic [CNT_W-1:0] arr_act,
    input  logic [CNT_W-1:0] arr_next,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q, base;

    always_comb begin
        base = dir ? arr_next : '0;
        wrap = tick && !reinit && (dir ? (cnt_q == '0) : (cnt_q == arr_act));
        cnt  = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (reinit) cnt_q <= base;
        else if (tick) begin
            if (wrap)     cnt_q <= base;
            else if (dir) cnt_q <= cnt_q - 1'b1;
            else          cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reinit && !wrap && !dir) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    assert_down_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reinit && !wrap && dir) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
    assert_up_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit && !dir) |=> (cnt_q == '0));
endmodule

// File: rtl/tbase_ctl.sv
module tbase_ctl
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_dir,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_opm,
    input  logic             cfg_urs,
    input  logic             cfg_udis,
    input  logic             upd_ie,
    input  logic             sw_ug,
    input  logic             slv_rst,
    input  logic             trig_start,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic [PSC_W-1:0] psc_pre,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uev_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             run_o,
    output logic             dir_o,
    output logic [CNT_W-1:0] arr_act_o,
    output logic [PSC_W-1:0] psc_act_o
);
    tb_cfg_t          cfg_q;
    logic [CNT_W-1:0] arr_act_q, arr_next;
    logic [PSC_W-1:0] psc_act_q;
    logic             run, tick, wrap, reinit, upd_now, flag_set;
    logic             uev_q, flag_q;
    cmode_t           mode_req;
    logic             mode_lock;

    // Event qualification
    always_comb begin
        reinit    = sw_ug || slv_rst;
        upd_now   = (wrap || reinit) && !cfg_q.udis;
        flag_set  = upd_now && (!cfg_q.urs || wrap);
        arr_next  = upd_now ? arr_pre : arr_act_q;
        mode_req  = cmode_t'(cfg_mode);
        mode_lock = run && (cfg_q.mode == MODE_EDGE) && (mode_req != MODE_EDGE);
    end

    // Configuration register with direction and mode locks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_EDGE, dir: 1'b0, opm: 1'b0, urs: 1'b0, udis: 1'b0};
        end else if (cfg_wr) begin
            cfg_q.opm  <= cfg_opm;
            cfg_q.urs  <= cfg_urs;
            cfg_q.udis <= cfg_udis;
            if (cfg_q.mode == MODE_EDGE) cfg_q.dir  <= cfg_dir;
            if (!mode_lock)              cfg_q.mode <= mode_req;
        end
    end

    // Shadow registers, event pulse and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_act_q <= '0;
            psc_act_q <= '0;
            uev_q     <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            uev_q <= upd_now;
            if (upd_now) begin
                arr_act_q <= arr_pre;
                psc_act_q <= psc_pre;
            end
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    tbase_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .trig_start(trig_start), .opm(cfg_q.opm), .upd_now(upd_now), .run(run)
    );

    tbase_presc #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .reinit(reinit),
        .psc_act(psc_act_q), .tick(tick)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reinit(reinit), .dir(cfg_q.dir),
        .arr_act(arr_act_q), .arr_next(arr_next), .wrap(wrap), .cnt(cnt_o)
    );

    always_comb begin
        uev_o     = uev_q;
        flag_o    = flag_q;
        irq_o     = flag_q && upd_ie;
        run_o     = run;
        dir_o     = cfg_q.dir;
        arr_act_o = arr_act_q;
        psc_act_o = psc_act_q;
    end

    assert_no_uev_udis_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.udis |=> !uev_q);
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.udis |=> $stable(arr_act_q));
    assert_shadow_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cfg_q.udis) |=> (arr_act_q == $past(arr_pre)));
    assert_urs_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.urs && reinit && !flag_q) |=> !flag_q);
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wrap && !reinit) |=> !flag_q);
    assert_dir_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_q.mode != MODE_EDGE) |=> (cfg_q.dir == $past(cfg_q.dir)));
    assert_mode_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && run && cfg_q.mode == MODE_EDGE) |=> (cfg_q.mode == MODE_EDGE));
endmodule

// File: tb/tbase_ctl_test.sv
module tbase_ctl_test;
    localparam int CW = 4;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_en = 0, cfg_dir = 0, cfg_opm = 0, cfg_urs = 0, cfg_udis = 0;
    logic [1:0] cfg_mode = 2'd0;
    logic upd_ie = 0, sw_ug = 0, slv_rst = 0, trig_start = 0, flag_clr = 0;
    logic [CW-1:0] arr_pre = '0;
    logic [PW-1:0] psc_pre = '0;
    logic [CW-1:0] cnt_o, arr_act_o;
    logic [PW-1:0] psc_act_o;
    logic uev_o, flag_o, irq_o, run_o, dir_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tbase_ctl #(.CNT_W(CW), .PSC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_mode(cfg_mode), .cfg_opm(cfg_opm), .cfg_urs(cfg_urs), .cfg_udis(cfg_udis),
        .upd_ie(upd_ie), .sw_ug(sw_ug), .slv_rst(slv_rst), .trig_start(trig_start),
        .flag_clr(flag_clr), .arr_pre(arr_pre), .psc_pre(psc_pre), .cnt_o(cnt_o),
        .uev_o(uev_o), .flag_o(flag_o), .irq_o(irq_o), .run_o(run_o), .dir_o(dir_o),
        .arr_act_o(arr_act_o), .psc_act_o(psc_act_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Reference model written from the requirements
    logic m_run, m_dir, m_opm, m_urs, m_udis, m_uev, m_flag;
    logic [1:0] m_mode;
    logic [CW-1:0] m_cnt, m_arr;
    logic [PW-1:0] m_psc, m_pc;

    always @(posedge clk) begin
        logic tk, wr, re, up, st;
        logic [CW-1:0] na, bs;
        if (!rst_n) begin
            m_run = 0; m_dir = 0; m_opm = 0; m_urs = 0; m_udis = 0; m_uev = 0; m_flag = 0;
            m_mode = 0; m_cnt = 0; m_arr = 0; m_psc = 0; m_pc = 0;
        end else begin
            re = sw_ug | slv_rst;
            tk = m_run && (m_pc == m_psc);
            wr = tk && !re && (m_dir ? (m_cnt == 0) : (m_cnt == m_arr));
            up = (wr | re) && !m_udis;
            na = up ? arr_pre : m_arr;
            bs = m_dir ? na : '0;
            if (re) m_cnt = bs;
            else if (tk) m_cnt = wr ? bs : (m_dir ? m_cnt - 1'b1 : m_cnt + 1'b1);
            if (re) m_pc = 0;
            else if (m_run) m_pc = tk ? '0 : m_pc + 1'b1;
            if (up && (!m_urs || wr)) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_uev = up;
            if (up) begin m_arr = arr_pre; m_psc = psc_pre; end
            st = m_run;
            if (cfg_wr) st = cfg_en;
            if (trig_start) st = 1;
            if (m_opm && up) st = 0;
            if (cfg_wr) begin
                if (m_mode == 0) m_dir = cfg_dir;
                if (!(m_mode == 0 && cfg_mode != 0 && m_run)) m_mode = cfg_mode;
                m_opm = cfg_opm; m_urs = cfg_urs; m_udis = cfg_udis;
            end
            m_run = st;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cnt_o == m_cnt, "R2 model cnt", cnt_o, m_cnt);
            chk(uev_o == m_uev, "R5 model uev", uev_o, m_uev);
            chk(flag_o == m_flag, "R6 model flag", flag_o, m_flag);
            chk(run_o == m_run, "R1 model run", run_o, m_run);
            chk(arr_act_o == m_arr, "R5 model arr shadow", arr_act_o, m_arr);
            chk(psc_act_o == m_psc, "R5 model psc shadow", psc_act_o, m_psc);
            chk(irq_o == (m_flag && upd_ie), "R7 model irq", irq_o, m_flag && upd_ie);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(input bit en, input bit dir, input int mode, input bit opm,
                       input bit urs, input bit udis);
        cfg_en = en; cfg_dir = dir; cfg_mode = mode[1:0]; cfg_opm = opm;
        cfg_urs = urs; cfg_udis = udis; cfg_wr = 1;
        step();
        cfg_wr = 0;
    endtask

    task automatic pulse_ug();
        sw_ug = 1; step(); sw_ug = 0;
    endtask

    task automatic load(input int arr, input int psc, input bit dir, input bit opm,
                        input bit urs, input bit udis);
        arr_pre = arr[CW-1:0]; psc_pre = psc[PW-1:0];
        cfg(0, dir, 0, opm, urs, 0);
        pulse_ug();
        if (udis) cfg(0, dir, 0, opm, urs, 1);
    endtask

    task automatic clr_flag();
        flag_clr = 1; step(); flag_clr = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(run_o == 0, "R1 reset run", run_o, 0);
        chk(cnt_o == 0, "R1 reset cnt", cnt_o, 0);
        chk(uev_o == 0 && flag_o == 0, "R1 reset uev/flag", {uev_o, flag_o}, 0);
        cmp_on = 1;

        // R2 sweep: three wraps per window of 3*(arr+1)*(psc+1) cycles
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 1; a < 5; a++) begin
                    int n;
                    load(a, p, d[0], 0, 0, 0);
                    cfg(1, d[0], 0, 0, 0, 0);
                    n = 0;
                    repeat (3 * (a + 1) * (p + 1)) begin
                        step();
                        if (uev_o) n++;
                    end
                    chk(n == 3, "R2 wrap period", n, 3);
                end
            end
        end
        cfg(0, 0, 0, 0, 0, 0);

        // R1 trigger start and software stop
        trig_start = 1; step(); trig_start = 0;
        chk(run_o == 1, "R1 trigger start", run_o, 1);
        cfg(0, 0, 0, 0, 0, 0);
        chk(run_o == 0, "R1 software stop", run_o, 0);

        // R3 one-pulse
        load(2, 0, 0, 1, 0, 0);
        cfg(1, 0, 0, 1, 0, 0);
        repeat (3) step();
        chk(run_o == 0, "R3 one-pulse stop", run_o, 0);
        chk(cnt_o == 0, "R3 one-pulse cnt", cnt_o, 0);
        repeat (3) step();
        chk(cnt_o == 0 && run_o == 0, "R3 stays stopped", cnt_o, 0);

        // R4 update disable
        load(3, 1, 0, 0, 0, 0);
        clr_flag();
        cfg(1, 0, 0, 0, 0, 1);
        arr_pre = 4'd7; psc_pre = 3'd2;
        begin
            int n = 0;
            repeat (12) begin step(); if (uev_o) n++; end
            chk(n == 0, "R4 no update event", n, 0);
        end
        chk(arr_act_o == 3, "R4 arr shadow held", arr_act_o, 3);
        chk(psc_act_o == 1, "R4 psc shadow held", psc_act_o, 1);
        pulse_ug();
        chk(cnt_o == 0, "R4 ug reinit cnt", cnt_o, 0);
        chk(uev_o == 0 && flag_o == 0, "R4 ug no event", {uev_o, flag_o}, 0);
        step();
        chk(cnt_o == 0, "R4 prescaler cleared", cnt_o, 0);
        step();
        chk(cnt_o == 1, "R4 first tick after clear", cnt_o, 1);
        slv_rst = 1; step(); slv_rst = 0;
        chk(cnt_o == 0 && uev_o == 0, "R4 slave reinit", cnt_o, 0);
        cfg(0, 0, 0, 0, 0, 0);

        // R5 event pulse is one cycle, shadows load
        arr_pre = 4'd6; psc_pre = 3'd1;
        pulse_ug();
        chk(uev_o == 1, "R5 uev pulse", uev_o, 1);
        chk(arr_act_o == 6 && psc_act_o == 1, "R5 shadows loaded", arr_act_o, 6);
        step();
        chk(uev_o == 0, "R5 pulse single cycle", uev_o, 0);

        // R6 collision of wrap and ug with urs=1
        load(2, 0, 0, 0, 1, 0);
        clr_flag();
        cfg(1, 0, 0, 0, 1, 0);
        repeat (3) step();
        chk(flag_o == 1, "R6 wrap sets flag urs=1", flag_o, 1);
        clr_flag();
        step();
        sw_ug = 1; step(); sw_ug = 0;
        chk(uev_o == 1, "R6 collision uev", uev_o, 1);
        chk(flag_o == 0, "R6 collision urs=1 no flag", flag_o, 0);
        chk(cnt_o == 0, "R6 collision cnt", cnt_o, 0);
        // same collision with urs=0, plus a clear on the same edge (R7)
        load(2, 0, 0, 0, 0, 0);
        clr_flag();
        cfg(1, 0, 0, 0, 0, 0);
        repeat (3) step();
        clr_flag();
        step();
        sw_ug = 1; flag_clr = 1; step(); sw_ug = 0; flag_clr = 0;
        chk(flag_o == 1, "R6 R7 collision urs=0 set wins", flag_o, 1);
        upd_ie = 1; #1;
        chk(irq_o == 1, "R7 irq enabled", irq_o, 1);
        upd_ie = 0; #1;
        chk(irq_o == 0, "R7 irq masked", irq_o, 0);
        cfg(0, 0, 0, 0, 0, 0);
        clr_flag();
        chk(flag_o == 0, "R7 flag cleared", flag_o, 0);

        // R10 down-count reinit values
        load(3, 0, 1, 0, 0, 0);
        chk(cnt_o == 3, "R10 down reinit", cnt_o, 3);
        arr_pre = 4'd5; pulse_ug();
        chk(cnt_o == 5, "R10 down reinit new arr", cnt_o, 5);
        cfg(0, 1, 0, 0, 0, 1);
        arr_pre = 4'd9; pulse_ug();
        chk(cnt_o == 5 && arr_act_o == 5, "R10 down reinit held arr", cnt_o, 5);

        // R8 direction locked in non-edge mode
        load(9, 0, 0, 0, 0, 0);
        cfg(0, 0, 1, 0, 0, 0);
        cfg(1, 1, 1, 0, 0, 0);
        chk(dir_o == 0, "R8 dir locked", dir_o, 0);
        step(); step();
        chk(cnt_o == 2, "R8 still counts up", cnt_o, 2);
        cfg(0, 0, 0, 0, 0, 0);

        // R9 mode change refused while running
        load(9, 0, 0, 0, 0, 0);
        cfg(1, 0, 0, 0, 0, 0);
        cfg(1, 1, 1, 0, 0, 0);
        chk(dir_o == 1, "R9 dir applied in edge mode", dir_o, 1);
        cfg(1, 0, 1, 0, 0, 0);
        chk(dir_o == 0, "R9 mode stayed edge", dir_o, 0);
        cfg(0, 0, 0, 0, 0, 0);

        step();
        done = 1;
        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule